// File: doc/BRIEF.md
# Mode-Switched Serial Load and Status Shifter

This block is the configuration front end of a multi-channel LED driver. A host sends a bit stream on a serial data pin together with a data clock. The bits go into a shift register MSB first, and the last active stage drives a serial output so that several drivers can be chained. A mode input sets the chain length:
- 192 bits (16 channels of 12-bit brightness) when low.
- 96 bits (16 channels of 6-bit current trim) when high.

A level-sensitive latch strobe copies the shifter into the brightness register or the trim register, depending on the mode.

When a brightness latch ends, the shifter is refilled with a 192-bit status word, which the host reads back on the serial output while it sends the next frame. The status word holds the per-channel open-load flags, the thermal flag and a copy of the trim register. The first brightness update after a trim load takes effect only when one extra data-clock pulse arrives after the strobe.

All pin-level inputs are treated as synchronous to a faster system clock and are edge-detected inside the block. The PWM engine and the fault sensing sit outside the block and meet it at its ports.

Top module: `ledsh_serial_loader`

## Requirements
- R1: On each rising edge of `sclk_i` with `xlat_i` low, `sin_i` enters bit 0 of the shifter and all bits move up one place. In brightness mode (`mode_i`=0), `sout_o` is bit 191, so a frame entered MSB first leaves `sout_o` in the same order 192 pulses later.
- R2: In trim mode (`mode_i`=1), `sout_o` is bit 95, so the chain delay is 96 data-clock pulses.
- R3: While `xlat_i` is high, the selected register follows the shifter. In brightness mode `gs_reg_o` takes all 192 bits. In trim mode `dc_reg_o` takes the low 96 bits. Channel 15 occupies the most significant field of each register.
- R4: While `xlat_i` is low, `gs_reg_o` and `dc_reg_o` hold their values through any serial shifting. The one exception is the deferred commit of R6.
- R5: When `xlat_i` falls in brightness mode, the shifter is loaded with the status word. Its bits 15:0 are the open-load flags `lod_i`, bit 16 is `tef_i`, bits 119:24 are `dc_reg_o`, and all other bits are zero. `sout_o` shows status bit 191 at once, and each later pulse shifts out the next lower bit.
- R6: After a trim latch, the next brightness strobe leaves `gs_reg_o` unchanged. The first rising `sclk_i` after that strobe falls then does three things: it commits the shifter to `gs_reg_o`, discards `sin_i`, and loads the status word of R5.
- R7: Rising edges of `sclk_i` while `xlat_i` is high do not move the shifter.
- R8: `proto_err_o` pulses high for one cycle when `mode_i` changes while `xlat_i` was high in both the current and the previous cycle.
- R9: `gs_valid_o` and `dc_valid_o` are cleared by reset. Each is set by the first write into its register and then stays set.
- R10: After reset, the shifter and both registers are zero and `sout_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_i | input | 1 | Serial data clock, sampled |
| sin_i | input | 1 | Serial data in |
| xlat_i | input | 1 | Level-sensitive latch strobe |
| mode_i | input | 1 | 0 = brightness (192-bit), 1 = trim (96-bit) |
| lod_i | input | 16 | Per-channel open-load flags |
| tef_i | input | 1 | Thermal flag |
| sout_o | output | 1 | Serial data out, last active stage |
| gs_reg_o | output | 192 | Brightness register, 16 x 12 bits |
| dc_reg_o | output | 96 | Trim register, 16 x 6 bits |
| gs_valid_o | output | 1 | Brightness register written since reset |
| dc_valid_o | output | 1 | Trim register written since reset |
| proto_err_o | output | 1 | Mode changed while strobe high |

## Verification
The hardest case to reach is the deferred brightness commit. It appears only after a trim latch, followed by a mode change, a full 192-bit frame and a brightness strobe. The bench builds that exact sequence. It checks that the brightness register has kept its old value after the strobe. It then sends a single extra pulse and checks that the new frame is committed. Finally it reads out the whole status word and checks that it carries the trim data just loaded. This shows that the extra pulse also replaced the shifter contents.

// File: rtl/ledsh_pkg.sv
// Package: shared sizes, the update-state type and the status-word builder
// for the serial loader. Assumes 16 channels; all widths derive from the
// channel count and the per-channel field sizes.
package ledsh_pkg;
    localparam int CH      = 16;
    localparam int GS_BITS = 12;
    localparam int DC_BITS = 6;
    localparam int GS_W    = CH * GS_BITS;
    localparam int DC_W    = CH * DC_BITS;
    localparam int TEF_POS = CH;
    localparam int DC_LSB  = 24;

    // Progress of a brightness update relative to a preceding trim load
    typedef enum logic [1:0] {
        ST_NORMAL     = 2'd0,
        ST_AFTER_DC   = 2'd1,
        ST_WAIT_EXTRA = 2'd2
    } upd_state_e;

    // Assemble the readback word: flags low, thermal bit, trim copy, zeros
    function automatic logic [GS_W-1:0] pack_status(
        input logic [CH-1:0]   lod,
        input logic            tef,
        input logic [DC_W-1:0] dc
    );
        logic [GS_W-1:0] s;
        s = '0;
        s[CH-1:0]         = lod;
        s[TEF_POS]        = tef;
        s[DC_LSB +: DC_W] = dc;
        return s;
    endfunction
endpackage

// File: rtl/ledsh_edge_sampler.sv
// Edge sampler: keeps one-cycle-old copies of the data clock, strobe and
// mode pins. From them it derives the clock rise, the strobe fall and the
// protocol-error pulse. Assumes inputs are already synchronous to clk.
module ledsh_edge_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic xlat_i,
    input  logic mode_i,
    output logic sclk_rise,
    output logic xlat_fall,
    output logic proto_err
);
    logic sclk_q;
    logic xlat_q;
    logic mode_q;

    // Delay each control pin by one cycle for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            xlat_q <= 1'b0;
            mode_q <= 1'b0;
        end else begin
            sclk_q <= sclk_i;
            xlat_q <= xlat_i;
            mode_q <= mode_i;
        end
    end

    // Flag a mode change made during a held strobe, one cycle wide
    always_ff @(posedge clk) begin
        if (!rst_n) proto_err <= 1'b0;
        else        proto_err <= xlat_i & xlat_q & (mode_i ^ mode_q);
    end

    assign sclk_rise = sclk_i & ~sclk_q;
    assign xlat_fall = ~xlat_i & xlat_q;
endmodule

// File: rtl/ledsh_shift_core.sv
// Shift core: the full-length serial shifter. A status load takes priority
// over a shift. The serial output taps the top of the 96-bit or the 192-bit
// chain, chosen by the current mode.
module ledsh_shift_core #(
    parameter int GS_W = ledsh_pkg::GS_W,
    parameter int DC_W = ledsh_pkg::DC_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            shift_en,
    input  logic            load_en,
    input  logic            sin,
    input  logic            mode_dc,
    input  logic [GS_W-1:0] status_vec,
    output logic [GS_W-1:0] sr,
    output logic            sout
);
    // Load status, or shift one bit in at the bottom
    always_ff @(posedge clk) begin
        if (!rst_n)        sr <= '0;
        else if (load_en)  sr <= status_vec;
        else if (shift_en) sr <= {sr[GS_W-2:0], sin};
    end

    // Pick the last stage of whichever chain is active
    assign sout = mode_dc ? sr[DC_W-1] : sr[GS_W-1];
endmodule

// File: rtl/ledsh_latch_ctrl.sv
// Latch control: the strobe-level copy into the brightness or trim register,
// the valid flags, and the small state machine that defers the first
// brightness commit after a trim load. It also decides when the shifter
// shifts and when it takes the status word.
module ledsh_latch_ctrl #(
    parameter int GS_W = ledsh_pkg::GS_W,
    parameter int DC_W = ledsh_pkg::DC_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            xlat_i,
    input  logic            mode_i,
    input  logic            sclk_rise,
    input  logic            xlat_fall,
    input  logic [GS_W-1:0] sr,
    output logic [GS_W-1:0] gs_reg,
    output logic [DC_W-1:0] dc_reg,
    output logic            gs_valid,
    output logic            dc_valid,
    output logic            shift_en,
    output logic            load_en,
    output logic            commit
);
    import ledsh_pkg::*;

    upd_state_e state;
    logic       gs_follow;
    logic       dc_follow;

    // Decode follow, commit, shift and status-load conditions
    always_comb begin
        gs_follow = xlat_i & ~mode_i & (state == ST_NORMAL);
        dc_follow = xlat_i & mode_i;
        commit    = sclk_rise & ~xlat_i & ~mode_i & (state == ST_WAIT_EXTRA);
        load_en   = commit | (xlat_fall & ~mode_i & (state == ST_NORMAL));
        shift_en  = sclk_rise & ~xlat_i & ~commit;
    end

    // Track whether a trim load has left a brightness update pending
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_NORMAL;
        else if (xlat_fall & mode_i)
            state <= ST_AFTER_DC;
        else if (xlat_fall & ~mode_i & (state == ST_AFTER_DC))
            state <= ST_WAIT_EXTRA;
        else if (commit)
            state <= ST_NORMAL;
    end

    // Brightness register: follow the strobe, or take the deferred commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gs_reg   <= '0;
            gs_valid <= 1'b0;
        end else if (gs_follow | commit) begin
            gs_reg   <= sr;
            gs_valid <= 1'b1;
        end
    end

    // Trim register: follow the strobe in trim mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dc_reg   <= '0;
            dc_valid <= 1'b0;
        end else if (dc_follow) begin
            dc_reg   <= sr[DC_W-1:0];
            dc_valid <= 1'b1;
        end
    end
endmodule

// File: rtl/ledsh_serial_loader.sv
// Serial loader top: connects the edge sampler, the shift core and the latch
// control, and builds the status word from the fault inputs and the trim
// register. Assumes all pins are synchronous to clk.
module ledsh_serial_loader (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sclk_i,
    input  logic                      sin_i,
    input  logic                      xlat_i,
    input  logic                      mode_i,
    input  logic [ledsh_pkg::CH-1:0]  lod_i,
    input  logic                      tef_i,
    output logic                      sout_o,
    output logic [ledsh_pkg::GS_W-1:0] gs_reg_o,
    output logic [ledsh_pkg::DC_W-1:0] dc_reg_o,
    output logic                      gs_valid_o,
    output logic                      dc_valid_o,
    output logic                      proto_err_o
);
    import ledsh_pkg::*;

    logic            sclk_rise;
    logic            xlat_fall;
    logic            shift_en;
    logic            load_en;
    logic            commit;
    logic [GS_W-1:0] sr_q;
    logic [GS_W-1:0] status_vec;

    // Status word presented to the shifter on a brightness latch or commit
    always_comb status_vec = pack_status(lod_i, tef_i, dc_reg_o);

    ledsh_edge_sampler u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_i    (sclk_i),
        .xlat_i    (xlat_i),
        .mode_i    (mode_i),
        .sclk_rise (sclk_rise),
        .xlat_fall (xlat_fall),
        .proto_err (proto_err_o)
    );

    ledsh_shift_core #(.GS_W(GS_W), .DC_W(DC_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_en   (shift_en),
        .load_en    (load_en),
        .sin        (sin_i),
        .mode_dc    (mode_i),
        .status_vec (status_vec),
        .sr         (sr_q),
        .sout       (sout_o)
    );

    ledsh_latch_ctrl #(.GS_W(GS_W), .DC_W(DC_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .xlat_i    (xlat_i),
        .mode_i    (mode_i),
        .sclk_rise (sclk_rise),
        .xlat_fall (xlat_fall),
        .sr        (sr_q),
        .gs_reg    (gs_reg_o),
        .dc_reg    (dc_reg_o),
        .gs_valid  (gs_valid_o),
        .dc_valid  (dc_valid_o),
        .shift_en  (shift_en),
        .load_en   (load_en),
        .commit    (commit)
    );
endmodule

// File: rtl/ledsh_serial_loader_chk.sv
// Checker for the serial loader: temporal properties on the ports and on the
// shifter and commit signals, attached to the top by the bind below.
module ledsh_serial_loader_chk (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       xlat_i,
    input logic                       mode_i,
    input logic                       commit,
    input logic [ledsh_pkg::GS_W-1:0] sr_q,
    input logic [ledsh_pkg::GS_W-1:0] gs_reg_o,
    input logic [ledsh_pkg::DC_W-1:0] dc_reg_o,
    input logic                       gs_valid_o,
    input logic                       dc_valid_o,
    input logic                       proto_err_o
);
    // R4: brightness register holds while strobe low, except on commit
    assert_gs_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!xlat_i && !commit) |=> $stable(gs_reg_o));

    // R4: trim register changes only under a trim-mode strobe
    assert_dc_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(xlat_i && mode_i) |=> $stable(dc_reg_o));

    // R7: shifter frozen while strobe high
    assert_sr_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        xlat_i |=> $stable(sr_q));

    // R9: valid flags never drop once set
    assert_gs_valid_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        gs_valid_o |=> gs_valid_o);
    assert_dc_valid_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dc_valid_o |=> dc_valid_o);
    assert_dc_valid_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dc_valid_o) |-> $past(xlat_i && mode_i));

    // R8: an error pulse only follows a held strobe and lasts one cycle
    assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err_o |-> $past(xlat_i));
    assert_err_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err_o |=> !proto_err_o);
endmodule

bind ledsh_serial_loader ledsh_serial_loader_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .xlat_i      (xlat_i),
    .mode_i      (mode_i),
    .commit      (commit),
    .sr_q        (sr_q),
    .gs_reg_o    (gs_reg_o),
    .dc_reg_o    (dc_reg_o),
    .gs_valid_o  (gs_valid_o),
    .dc_valid_o  (dc_valid_o),
    .proto_err_o (proto_err_o)
);

// File: tb/sim_ledsh_serial_loader.sv
module sim_ledsh_serial_loader;
    localparam int CLK_PERIOD = 10;
    localparam int GW = 192;
    localparam int DW = 96;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           sclk_i = 1'b0;
    logic           sin_i = 1'b0;
    logic           xlat_i = 1'b0;
    logic           mode_i = 1'b0;
    logic [15:0]    lod_i = '0;
    logic           tef_i = 1'b0;
    logic           sout_o;
    logic [GW-1:0]  gs_reg_o;
    logic [DW-1:0]  dc_reg_o;
    logic           gs_valid_o;
    logic           dc_valid_o;
    logic           proto_err_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ledsh_serial_loader u0 (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .sin_i(sin_i),
        .xlat_i(xlat_i), .mode_i(mode_i), .lod_i(lod_i), .tef_i(tef_i),
        .sout_o(sout_o), .gs_reg_o(gs_reg_o), .dc_reg_o(dc_reg_o),
        .gs_valid_o(gs_valid_o), .dc_valid_o(dc_valid_o),
        .proto_err_o(proto_err_o)
    );

    // Expected status word: flags 15:0, thermal 16, trim 119:24, zeros elsewhere
    function automatic logic [GW-1:0] exp_status(input logic [15:0] lod,
                                                 input logic tef,
                                                 input logic [DW-1:0] dc);
        logic [GW-1:0] s;
        s = '0;
        s[15:0]   = lod;
        s[16]     = tef;
        s[119:24] = dc;
        return s;
    endfunction

    function automatic logic [GW-1:0] rand_vec();
        logic [GW-1:0] v;
        for (int k = 0; k < GW/32; k++) v[k*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic chk(input bit ok, input string req,
                       input logic [GW-1:0] act, input logic [GW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Send n bits of v MSB first; record sout before each rising edge
    task automatic shift_vec(input logic [GW-1:0] v, input int n,
                             output logic [GW-1:0] cap);
        cap = '0;
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk);
            cap[i] = sout_o;
            sin_i  = v[i];
            sclk_i = 1'b1;
            @(negedge clk);
            sclk_i = 1'b0;
        end
        @(negedge clk);
    endtask

    task automatic strobe();
        @(negedge clk) xlat_i = 1'b1;
        repeat (3) @(negedge clk);
        xlat_i = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [GW-1:0] cap, v, prev_v, w, x, v3;
        logic [GW-1:0] prev_status;
        logic [DW-1:0] d, e;
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk(gs_reg_o == '0, "R10 gs_reg", gs_reg_o, '0);
        chk(dc_reg_o == '0, "R10 dc_reg", GW'(dc_reg_o), '0);
        chk(sout_o == 1'b0, "R10 sout", GW'(sout_o), '0);
        chk(!gs_valid_o && !dc_valid_o, "R9 valid after reset", GW'({gs_valid_o, dc_valid_o}), '0);
        chk(proto_err_o == 1'b0, "R8 err after reset", GW'(proto_err_o), '0);

        // R1 R3 R5: random brightness frames, status readback each round
        prev_status = '0;
        prev_v = '0;
        for (int r = 0; r < 3; r++) begin
            v = rand_vec();
            shift_vec(v, GW, cap);
            if (r > 0) chk(cap == prev_status, "R5 status readout", cap, prev_status);
            lod_i = 16'($urandom);
            tef_i = 1'($urandom);
            strobe();
            chk(gs_reg_o == v, "R3 gs latch", gs_reg_o, v);
            chk(gs_valid_o && !dc_valid_o, "R9 gs valid only", GW'({gs_valid_o, dc_valid_o}), GW'(2'b10));
            prev_status = exp_status(lod_i, tef_i, '0);
            prev_v = v;
        end
        chk(sout_o == prev_status[GW-1], "R5 status MSB at once", GW'(sout_o), GW'(prev_status[GW-1]));

        // R4: shifting without a strobe leaves the register alone
        w = rand_vec();
        shift_vec(w, GW, cap);
        chk(cap == prev_status, "R5 status readout last", cap, prev_status);
        chk(gs_reg_o == prev_v, "R4 gs hold", gs_reg_o, prev_v);

        // R2: trim mode has a 96-bit chain
        @(negedge clk) mode_i = 1'b1;
        @(negedge clk);
        d = DW'(rand_vec());
        shift_vec(GW'(d), DW, cap);
        chk(cap[DW-1:0] == w[DW-1:0], "R2 trim chain tap", GW'(cap[DW-1:0]), GW'(w[DW-1:0]));
        strobe();
        chk(dc_reg_o == d, "R3 dc latch", GW'(dc_reg_o), GW'(d));
        chk(dc_valid_o, "R9 dc valid", GW'(dc_valid_o), GW'(1));
        chk(gs_reg_o == prev_v, "R4 gs unchanged by trim latch", gs_reg_o, prev_v);
        e = DW'(rand_vec());
        shift_vec(GW'(e), DW, cap);
        chk(cap[DW-1:0] == d, "R2 trim chain 96 delay", GW'(cap[DW-1:0]), GW'(d));
        chk(dc_reg_o == d, "R4 dc hold", GW'(dc_reg_o), GW'(d));

        // R6: first brightness latch after trim waits for an extra pulse
        @(negedge clk) mode_i = 1'b0;
        @(negedge clk);
        v3 = rand_vec();
        shift_vec(v3, GW, cap);
        strobe();
        chk(gs_reg_o == prev_v, "R6 deferred no commit", gs_reg_o, prev_v);
        shift_vec(GW'(1), 1, cap);
        chk(gs_reg_o == v3, "R6 commit on extra pulse", gs_reg_o, v3);
        prev_status = exp_status(lod_i, tef_i, d);
        x = rand_vec();
        shift_vec(x, GW, cap);
        chk(cap == prev_status, "R6 status after commit", cap, prev_status);

        // R7: data-clock edges under a held strobe do not shift
        @(negedge clk) xlat_i = 1'b1;
        for (int p = 0; p < 3; p++) begin
            @(negedge clk) sclk_i = 1'b1; sin_i = ~sin_i;
            @(negedge clk) sclk_i = 1'b0;
        end
        @(negedge clk) xlat_i = 1'b0;
        repeat (2) @(negedge clk);
        chk(gs_reg_o == x, "R7 sclk ignored during strobe", gs_reg_o, x);

        // R8: mode change during a held strobe
        @(negedge clk) xlat_i = 1'b1;
        repeat (2) @(negedge clk);
        chk(proto_err_o == 1'b0, "R8 no err before change", GW'(proto_err_o), '0);
        mode_i = 1'b1;
        @(negedge clk);
        chk(proto_err_o == 1'b1, "R8 err pulse", GW'(proto_err_o), GW'(1));
        @(negedge clk);
        chk(proto_err_o == 1'b0, "R8 err one cycle", GW'(proto_err_o), '0);
        xlat_i = 1'b0;
        repeat (2) @(negedge clk);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule